// File: doc/BRIEF.md
# Time-to-Digital Converter Register Configuration Sequencer

This block programs an external time-to-digital converter over a parallel address and data bus. It starts by itself on the first clock after reset. It writes a short, fixed list of configuration registers, one after another. Each write is a multi-cycle transaction. The chip select and address come first, the data follows, the active-low write strobe is pulsed, and then the signals are released in reverse order. Every phase lasts a whole number of clock cycles, so the chip's address setup, data setup and data-valid times are met with margin at a 50 MHz clock.

When the list is finished, the block raises a one-cycle done pulse and returns the bus to idle. While the block is idle, a start pulse reruns the whole list. A read request performs a single register read-back: the address is set up, the active-low read strobe is held for a data-valid wait, and the returned word is captured at a clock edge. While a transaction is running, start and read requests are ignored. The register addresses and values come from a constant table in the package.

Top module: `tdcseq_top`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, the outputs are idle: tdc_cs_n=1, tdc_we_n=1, tdc_oe_n=1, tdc_addr=0, tdc_wdata=0, done=0, busy=0, rd_valid=0. On the first clock edge with reset low, the write list starts without any start pulse, so chip select goes low in the cycle that follows.
- R2: The list writes register address 4 first and register address 5 second. The data for address 4 is 28'h4000000 (bits 27..22 = 010000, all other bits zero). The data for address 5 is 28'h0C00000 (bits 27..22 = 000011).
- R3: With default parameters, each register write lasts exactly 12 cycles:
  - 2 cycles with tdc_cs_n low, the address driven and tdc_wdata at zero;
  - 3 cycles with the data also driven;
  - 3 cycles with tdc_we_n low;
  - 2 cycles with tdc_we_n high again while tdc_cs_n stays low;
  - 2 cycles with tdc_cs_n high and address and data back at zero.
  Two registers therefore take 24 cycles (480 ns at 50 MHz).
- R4: tdc_addr does not change during any run of consecutive cycles in which tdc_cs_n is low.
- R5: Write data is present for at least one cycle before tdc_we_n falls. It stays unchanged up to and including the cycle in which tdc_we_n rises. tdc_we_n and tdc_oe_n are low only while tdc_cs_n is low.
- R6: In the cycle after the last write's final chip-select-high cycle, done is high for exactly one cycle. In that cycle the bus is idle and busy is low.
- R7: start and rd_req have no effect while busy is high. The running transaction continues unchanged.
- R8: A start pulse is accepted when the block is idle and also during the done cycle. If it arrives in the done cycle, the next cycle is the first address cycle of a new run.
- R9: A read of rd_addr lasts 8 cycles:
  - 2 address cycles;
  - 2 cycles with tdc_oe_n low;
  - 2 cycles with tdc_oe_n high and tdc_cs_n low;
  - 2 cycles with chip select high.
  tdc_rdata is captured at the clock edge that ends the second strobe cycle. rd_valid is high for one cycle, the first release cycle, with rd_data holding the captured word.
- R10: If start and rd_req are both high when the block is idle, the write list runs and the read is dropped.
- R11: busy is high in every cycle from the first address cycle to the last chip-select-high cycle of a write list or of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Rerun the configuration list |
| rd_req | input | 1 | Request a single register read |
| rd_addr | input | ADDR_W | Register address for the read |
| tdc_rdata | input | DATA_W | Data bus returned by the converter |
| tdc_cs_n | output | 1 | Active-low chip select |
| tdc_addr | output | ADDR_W | Register address bus |
| tdc_wdata | output | DATA_W | Write data bus |
| tdc_we_n | output | 1 | Active-low write strobe |
| tdc_oe_n | output | 1 | Active-low read strobe |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| rd_data | output | DATA_W | Word captured by the last read |
| busy | output | 1 | A write list or a read is in progress |
| done | output | 1 | One-cycle pulse at the end of the write list |

## Verification
A wrong phase or a wrong phase-counter value changes the shape of the bus. A strobe that starts early, or a chip select that is released one cycle late, appears in the very next cycle. The bench compares all bus outputs against a cycle-accurate model on every clock. A wrong register index shows up as a bad address or data word in the first address or data cycle of that register. A wrong capture point in a read changes rd_data, or moves the rd_valid cycle, within the same transaction. A wrong idle or accept condition shifts the whole expected sequence, so the mismatch is reported within one cycle.

// File: rtl/tdcseq_pkg.sv
package tdcseq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_STRB,
    PH_HOLD,
    PH_GAP,
    PH_DONE,
    PH_RADDR,
    PH_RSTRB,
    PH_RREL
  } phase_e;

  // Constant configuration table: register address for entry i
  function automatic logic [31:0] cfg_addr(int i);
    return 32'(4 + i);
  endfunction

  // Constant configuration table: data word for entry i
  function automatic logic [31:0] cfg_data(int i);
    case (i)
      0:       return 32'h0400_0000;  // bits 27..22 = 010000
      1:       return 32'h00C0_0000;  // bits 27..22 = 000011
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/tdcseq_cfg_rom.sv
module tdcseq_cfg_rom #(
  parameter int N_REGS = 2,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 28,
  parameter int IDX_W  = 1
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  import tdcseq_pkg::*;

  logic [ADDR_W-1:0] addr_tab [N_REGS];
  logic [DATA_W-1:0] data_tab [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_entry
    assign addr_tab[g] = ADDR_W'(cfg_addr(g));
    assign data_tab[g] = DATA_W'(cfg_data(g));
  end

  assign addr = addr_tab[idx];
  assign data = data_tab[idx];
endmodule

// File: rtl/tdcseq_phase_timer.sv
module tdcseq_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/tdcseq_top.sv
module tdcseq_top #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 28,
  parameter int N_REGS   = 2,
  parameter int ADDR_CYC = 2,
  parameter int DATA_CYC = 3,
  parameter int STRB_CYC = 3,
  parameter int HOLD_CYC = 2,
  parameter int GAP_CYC  = 2,
  parameter int RD_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] tdc_rdata,
  output logic              tdc_cs_n,
  output logic [ADDR_W-1:0] tdc_addr,
  output logic [DATA_W-1:0] tdc_wdata,
  output logic              tdc_we_n,
  output logic              tdc_oe_n,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);
  import tdcseq_pkg::*;

  localparam int IDX_W   = (N_REGS > 1) ? $clog2(N_REGS) : 1;
  localparam int CYC_SUM = ADDR_CYC + DATA_CYC + STRB_CYC + HOLD_CYC + GAP_CYC + RD_CYC;
  localparam int CNT_W   = $clog2(CYC_SUM + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REGS - 1);

  phase_e            ph_q, ph_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              rd_op_q, rd_op_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic              pend_q;
  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              last;
  logic              cap;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;
  logic              cs_on_d;
  logic [ADDR_W-1:0] addr_d;

  tdcseq_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .last(last)
  );

  tdcseq_cfg_rom #(.N_REGS(N_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) rom_i (
    .idx(idx_d), .addr(rom_addr), .data(rom_data)
  );

  always_comb begin
    ph_d    = ph_q;
    idx_d   = idx_q;
    rd_op_d = rd_op_q;
    raddr_d = raddr_q;
    ld      = 1'b0;
    ld_val  = '0;
    cap     = 1'b0;
    case (ph_q)
      PH_IDLE, PH_DONE: begin
        ph_d = PH_IDLE;
        if (start || pend_q) begin
          ph_d = PH_ADDR; idx_d = '0; rd_op_d = 1'b0;
          ld = 1'b1; ld_val = CNT_W'(ADDR_CYC);
        end else if (rd_req) begin
          ph_d = PH_RADDR; rd_op_d = 1'b1; raddr_d = rd_addr;
          ld = 1'b1; ld_val = CNT_W'(ADDR_CYC);
        end
      end
      PH_ADDR: if (last) begin ph_d = PH_DATA; ld = 1'b1; ld_val = CNT_W'(DATA_CYC); end
      PH_DATA: if (last) begin ph_d = PH_STRB; ld = 1'b1; ld_val = CNT_W'(STRB_CYC); end
      PH_STRB: if (last) begin ph_d = PH_HOLD; ld = 1'b1; ld_val = CNT_W'(HOLD_CYC); end
      PH_HOLD: if (last) begin ph_d = PH_GAP;  ld = 1'b1; ld_val = CNT_W'(GAP_CYC);  end
      PH_GAP: if (last) begin
        if (rd_op_q)              ph_d = PH_IDLE;
        else if (idx_q == LAST_IDX) ph_d = PH_DONE;
        else begin
          ph_d = PH_ADDR; idx_d = idx_q + 1'b1;
          ld = 1'b1; ld_val = CNT_W'(ADDR_CYC);
        end
      end
      PH_RADDR: if (last) begin ph_d = PH_RSTRB; ld = 1'b1; ld_val = CNT_W'(RD_CYC); end
      PH_RSTRB: if (last) begin
        ph_d = PH_RREL; cap = 1'b1; ld = 1'b1; ld_val = CNT_W'(HOLD_CYC);
      end
      PH_RREL: if (last) begin ph_d = PH_GAP; ld = 1'b1; ld_val = CNT_W'(GAP_CYC); end
      default: ph_d = PH_IDLE;
    endcase
  end

  assign cs_on_d = ph_d inside {PH_ADDR, PH_DATA, PH_STRB, PH_HOLD, PH_RADDR, PH_RSTRB, PH_RREL};
  assign addr_d  = rd_op_d ? raddr_d : rom_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_IDLE;
      idx_q     <= '0;
      rd_op_q   <= 1'b0;
      raddr_q   <= '0;
      pend_q    <= 1'b1;
      tdc_cs_n  <= 1'b1;
      tdc_addr  <= '0;
      tdc_wdata <= '0;
      tdc_we_n  <= 1'b1;
      tdc_oe_n  <= 1'b1;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      ph_q      <= ph_d;
      idx_q     <= idx_d;
      rd_op_q   <= rd_op_d;
      raddr_q   <= raddr_d;
      if (ph_d == PH_ADDR) pend_q <= 1'b0;
      tdc_cs_n  <= !cs_on_d;
      tdc_addr  <= cs_on_d ? addr_d : '0;
      tdc_wdata <= (ph_d inside {PH_DATA, PH_STRB, PH_HOLD}) ? rom_data : '0;
      tdc_we_n  <= (ph_d != PH_STRB);
      tdc_oe_n  <= (ph_d != PH_RSTRB);
      rd_valid  <= cap;
      if (cap) rd_data <= tdc_rdata;
      busy      <= !(ph_d inside {PH_IDLE, PH_DONE});
      done      <= (ph_d == PH_DONE);
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!tdc_cs_n && $past(!tdc_cs_n)) |-> $stable(tdc_addr)); // R4
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(tdc_we_n) |-> ($past(!tdc_cs_n) && $stable(tdc_wdata))); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tdc_we_n || $rose(tdc_we_n)) |-> $stable(tdc_wdata)); // R5
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!tdc_we_n || !tdc_oe_n) |-> !tdc_cs_n); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (tdc_cs_n && !busy)); // R6
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(!tdc_oe_n) && tdc_oe_n && !tdc_cs_n)); // R9
  AST_BUSY_CS: assert property (@(posedge clk) disable iff (rst)
    !tdc_cs_n |-> busy); // R11
endmodule

// File: tb/tdcseq_top_tb_top.sv
module tdcseq_top_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int WDOG_LIMIT = 20000;

  typedef struct packed {
    logic        busy;
    logic        done;
    logic        cs_n;
    logic        we_n;
    logic        oe_n;
    logic [3:0]  addr;
    logic [27:0] wdata;
    logic        rv;
    logic [27:0] rdat;
  } obs_t;

  logic        clk = 1'b0;
  logic        rst, start, rd_req;
  logic [3:0]  rd_addr;
  logic [27:0] tdc_rdata;
  logic        tdc_cs_n, tdc_we_n, tdc_oe_n, rd_valid, busy, done;
  logic [3:0]  tdc_addr;
  logic [27:0] tdc_wdata, rd_data;

  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  bit   pend = 1'b1;
  bit   idle_ok = 1'b1;
  bit   last_done = 1'b0;
  obs_t exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdcseq_top dut_i (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .tdc_rdata(tdc_rdata), .tdc_cs_n(tdc_cs_n), .tdc_addr(tdc_addr),
    .tdc_wdata(tdc_wdata), .tdc_we_n(tdc_we_n), .tdc_oe_n(tdc_oe_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done)
  );

  function automatic logic [27:0] rd_model(logic [3:0] a);
    return {a, ~a, 20'hC3A5F};
  endfunction

  // Converter model: read data appears a few ns after the strobe and address
  assign #3 tdc_rdata = tdc_oe_n ? 28'h0 : rd_model(tdc_addr);

  function automatic obs_t mk(logic b, logic d, logic cs, logic we, logic oe,
                              logic [3:0] a, logic [27:0] w, logic rv, logic [27:0] rdat);
    obs_t o;
    o = '{busy: b, done: d, cs_n: cs, we_n: we, oe_n: oe, addr: a, wdata: w, rv: rv, rdat: rdat};
    return o;
  endfunction

  task automatic push(obs_t o, string tag, int n);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(o);
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_write(string first_tag);
    for (int i = 0; i < 2; i++) begin
      logic [3:0]  a;
      logic [27:0] d;
      a = 4'(4 + i);
      d = (i == 0) ? {6'b010000, 22'd0} : {6'b000011, 22'd0};
      push(mk(1, 0, 0, 1, 1, a, 28'd0, 0, 28'd0), (i == 0) ? first_tag : "R3", 1);
      push(mk(1, 0, 0, 1, 1, a, 28'd0, 0, 28'd0), "R3", 1);
      push(mk(1, 0, 0, 1, 1, a, d, 0, 28'd0), "R2", 3);
      push(mk(1, 0, 0, 0, 1, a, d, 0, 28'd0), "R5", 3);
      push(mk(1, 0, 0, 1, 1, a, d, 0, 28'd0), "R3", 2);
      push(mk(1, 0, 1, 1, 1, 4'd0, 28'd0, 0, 28'd0), "R11", 2);
    end
    push(mk(0, 1, 1, 1, 1, 4'd0, 28'd0, 0, 28'd0), "R6", 1);
  endtask

  task automatic push_read(logic [3:0] a);
    push(mk(1, 0, 0, 1, 1, a, 28'd0, 0, 28'd0), "R9", 2);
    push(mk(1, 0, 0, 1, 0, a, 28'd0, 0, 28'd0), "R9", 2);
    push(mk(1, 0, 0, 1, 1, a, 28'd0, 1, rd_model(a)), "R9", 1);
    push(mk(1, 0, 0, 1, 1, a, 28'd0, 0, 28'd0), "R9", 1);
    push(mk(1, 0, 1, 1, 1, 4'd0, 28'd0, 0, 28'd0), "R11", 2);
  endtask

  // Reference model: decides at each edge what the block accepts
  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete();
      tag_q.delete();
      pend = 1'b1;
    end else if (idle_ok) begin
      if (start || pend) begin
        if (pend)                 push_write("R1");
        else if (start && rd_req) push_write("R10");
        else if (last_done)       push_write("R8");
        else                      push_write("R3");
        pend = 1'b0;
      end else if (rd_req) begin
        push_read(rd_addr);
      end
    end else if ((start || rd_req) && exp_q.size() > 0) begin
      tag_q[0] = "R7";  // request while busy must not disturb the next cycle
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    obs_t  e;
    obs_t  act;
    string tag;
    bit    bad;
    cycles++;
    if (exp_q.size() > 0) begin
      e   = exp_q.pop_front();
      tag = tag_q.pop_front();
    end else begin
      e   = mk(0, 0, 1, 1, 1, 4'd0, 28'd0, 0, 28'd0);
      tag = rst ? "R1" : "R7";
    end
    act = mk(busy, done, tdc_cs_n, tdc_we_n, tdc_oe_n, tdc_addr, tdc_wdata, rd_valid,
             rd_valid ? rd_data : 28'd0);
    if (!e.rv) act.rdat = 28'd0;
    checks++;
    bad = (act !== e);
    if (bad) begin
      errors++;
      $display("FAIL %s cycle %0d: actual busy=%b done=%b cs_n=%b we_n=%b oe_n=%b addr=%h wdata=%h rv=%b rdata=%h expected busy=%b done=%b cs_n=%b we_n=%b oe_n=%b addr=%h wdata=%h rv=%b rdata=%h",
               tag, cycles, act.busy, act.done, act.cs_n, act.we_n, act.oe_n, act.addr, act.wdata,
               act.rv, act.rdat, e.busy, e.done, e.cs_n, e.we_n, e.oe_n, e.addr, e.wdata, e.rv, e.rdat);
    end
    idle_ok   = (exp_q.size() == 0) && !e.busy;
    last_done = e.done;
    if (cycles > WDOG_LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WDOG_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wait_done();
    cyc(1);
    while (!done) cyc(1);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; rd_req = 1'b0; rd_addr = 4'd0;
    cyc(3);                       // R1 reset state
    rst = 1'b0;                   // R1 automatic start
    cyc(5);
    start = 1'b1; rd_req = 1'b1;  // R7 ignored while busy
    rd_addr = 4'd9;
    cyc(1);
    start = 1'b0; rd_req = 1'b0;
    cyc(10);
    rd_req = 1'b1;                // R7 again during a strobe phase
    cyc(1);
    rd_req = 1'b0;
    wait_done();                  // R6
    cyc(4);
    rd_req = 1'b1; rd_addr = 4'd4; // R9 read-back of a configured register
    cyc(1);
    rd_req = 1'b0;
    cyc(12);
    rd_req = 1'b1; rd_addr = 4'd11; // R9 another address
    cyc(1);
    rd_req = 1'b0;
    cyc(12);
    start = 1'b1; rd_req = 1'b1; rd_addr = 4'd2; // R10 start wins
    cyc(1);
    start = 1'b0; rd_req = 1'b0;
    wait_done();
    start = 1'b1;                 // R8 restart in the done cycle
    cyc(1);
    start = 1'b0;
    wait_done();
    cyc(3);
    start = 1'b1;                 // R1 reset in the middle of a run
    cyc(1);
    start = 1'b0;
    cyc(7);
    rst = 1'b1;
    cyc(3);
    rst = 1'b0;
    wait_done();
    cyc(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule